// File: doc/BRIEF.md
# Request-Acknowledge Bus Handshake Synchronizer

This block carries a multi-bit word from one clock domain to another clock domain that runs asynchronously to it. The source side takes a word through a valid/ready pair and parks it in a holding register. It then raises a single request line. That request reaches the destination through a chain of destination-clocked flip-flops. When the destination sees the synchronized request rise, it registers the parked word and pulses a valid output for one cycle. It also raises an acknowledge, which returns to the source through its own flip-flop chain.

The exchange is four-phase. Request stays high until the returned acknowledge is seen high, then it falls. The destination drops acknowledge once it sees request low. The source only reopens its ready output after the returned acknowledge has fallen. Because only the request and acknowledge lines cross, and the parked word is frozen for the whole exchange, the destination never captures a word whose bits were sampled at different moments. Each domain has its own synchronous active-low reset.

Top module: `bus_handshake_cdc`

## Requirements
- R1: While its reset is asserted and in the first cycle after it, the source drives src_ready high. While the destination reset is asserted, dst_valid and dst_data are zero, and they stay zero until the first word arrives.
- R2: A word is taken only on a source clock edge where src_valid and src_ready are both high. src_ready is low in the source cycle right after such an edge.
- R3: Once a word has been taken, src_ready stays low for at least 2*STAGES source cycles and until the returned acknowledge has fallen. src_valid and src_data presented while src_ready is low have no effect, and the parked word does not change.
- R4: The exchange is four-phase. Request stays high until the returned acknowledge is seen high. After that, request stays low until the returned acknowledge is seen low. The destination acknowledge is high whenever dst_valid is high.
- R5: dst_valid is high for exactly one destination cycle per transferred word and is never high in two consecutive destination cycles.
- R6: When dst_valid is high, dst_data equals the word that was taken. dst_data does not change in any destination cycle where dst_valid is low.
- R7: Every word that is taken is delivered exactly once, in the order it was taken, and no pulse appears without a taken word.
- R8: When the destination clock is at least as fast as the source clock, src_ready returns high within 4*STAGES+12 source cycles after a word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Source side can take a word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_data | output | DATA_W | Last word delivered to the destination |
| dst_valid | output | 1 | One-cycle pulse marking a newly delivered word |

## Verification
Suppose the source state machine got stuck or left its wait state too early. The port would show it in the first source cycle after the word is taken: either ready stays high, or ready reopens before the minimum round trip, or it never reopens within the R8 bound. Suppose the parked word were overwritten, or the destination captured on the wrong edge. The next dst_valid pulse would then carry a word that does not match the head of the bench's queue of taken words. That shows within one round trip. A broken edge detector would show as a doubled pulse, or as a pulse with an empty queue, in the destination cycle that follows it.

// File: rtl/hsk_pkg.sv
`timescale 1ns/1ps
// Shared types for the request/acknowledge bus synchronizer.
// Assumes nothing beyond a two-bit state encoding.
package hsk_pkg;

    // Source-side handshake phases.
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,   // ready for a new word, request low
        SRC_REQ     = 2'd1,   // request high, waiting for acknowledge high
        SRC_RELEASE = 2'd2    // request low, waiting for acknowledge low
    } src_state_t;

endpackage

// File: rtl/hsk_sync_bit.sv
`timescale 1ns/1ps
// Single-bit flip-flop chain that brings a level into the clock domain of clk.
// Assumes the input is a registered level from another domain that changes
// slowly compared with clk. STAGES must be at least 2.
module hsk_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_rest
            // Later stages give metastability time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hsk_src_ctrl.sv
`timescale 1ns/1ps
// Source-side handshake controller.
// Takes a word on valid&ready, parks it in a holding register and runs the
// four-phase request/acknowledge exchange. Assumes ack_seen is already
// synchronized into this clock domain.
module hsk_src_ctrl
    import hsk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              ack_seen,
    output logic              req,
    output logic [DATA_W-1:0] hold
);

    src_state_t state;
    logic       take;

    // A word is taken only when idle and offered.
    assign take     = in_valid && (state == SRC_IDLE);
    assign in_ready = (state == SRC_IDLE);

    // Handshake phase sequencing and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SRC_IDLE;
            req   <= 1'b0;
        end else begin
            case (state)
                SRC_IDLE: begin
                    if (take) begin
                        state <= SRC_REQ;
                        req   <= 1'b1;
                    end
                end
                SRC_REQ: begin
                    if (ack_seen) begin
                        state <= SRC_RELEASE;
                        req   <= 1'b0;
                    end
                end
                SRC_RELEASE: begin
                    if (!ack_seen) state <= SRC_IDLE;
                end
                default: begin
                    state <= SRC_IDLE;
                    req   <= 1'b0;
                end
            endcase
        end
    end

    // Holding register, loaded only when a word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold <= '0;
        else if (take) hold <= in_data;
    end

endmodule

// File: rtl/hsk_dst_ctrl.sv
`timescale 1ns/1ps
// Destination-side capture controller.
// On the rising edge of the synchronized request it registers the parked bus,
// pulses valid for one cycle and raises acknowledge. Acknowledge falls once the
// synchronized request is low. Assumes bus is frozen while request is high.
module hsk_dst_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_seen,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              ack
);

    logic req_seen_q;
    logic req_rise;

    assign req_rise = req_seen && !req_seen_q;

    // Edge detection, capture, valid pulse and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_q <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            ack        <= 1'b0;
        end else begin
            req_seen_q <= req_seen;
            out_valid  <= req_rise;
            if (req_rise) begin
                out_data <= bus;
                ack      <= 1'b1;
            end else if (!req_seen) begin
                ack      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_handshake_cdc.sv
`timescale 1ns/1ps
// Multi-bit clock domain crossing by four-phase request/acknowledge.
// Only the request and acknowledge levels cross, each through its own
// STAGES-deep chain; the data bus is read by the destination only while it
// is frozen in the source holding register. The two clocks may be unrelated.
module bus_handshake_cdc #(
    parameter int DATA_W = 16,
    parameter int STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_valid
);

    logic              req_src;
    logic              req_dst;
    logic              ack_dst;
    logic              ack_src;
    logic [DATA_W-1:0] hold_bus;

    hsk_src_ctrl #(.DATA_W(DATA_W)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .in_valid (src_valid),
        .in_data  (src_data),
        .in_ready (src_ready),
        .ack_seen (ack_src),
        .req      (req_src),
        .hold     (hold_bus)
    );

    hsk_sync_bit #(.STAGES(STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (req_src),
        .q     (req_dst)
    );

    hsk_dst_ctrl #(.DATA_W(DATA_W)) u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_seen  (req_dst),
        .bus       (hold_bus),
        .out_data  (dst_data),
        .out_valid (dst_valid),
        .ack       (ack_dst)
    );

    hsk_sync_bit #(.STAGES(STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (ack_dst),
        .q     (ack_src)
    );

endmodule

// File: rtl/bus_handshake_cdc_chk.sv
`timescale 1ns/1ps
// Protocol checker for bus_handshake_cdc, attached by bind.
// Observes both domains; each property uses the clock and reset of its domain.
module bus_handshake_cdc_chk #(
    parameter int DATA_W = 16
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              src_valid,
    input logic              src_ready,
    input logic              src_req,
    input logic              src_ack_seen,
    input logic [DATA_W-1:0] hold,
    input logic              dst_clk,
    input logic              dst_rst_n,
    input logic              dst_valid,
    input logic [DATA_W-1:0] dst_data,
    input logic              dst_ack
);

    // R2: a taken word closes ready on the next source cycle.
    p_ready_drop_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_valid && src_ready) |=> !src_ready);

    // R3: the parked word does not move while ready is low.
    p_hold_frozen_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_ready |=> $stable(hold));

    // R3: ready only while both handshake lines are low.
    p_ready_idle_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_ready |-> (!src_req && !src_ack_seen));

    // R4: request held until acknowledge seen high.
    p_req_held_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req && !src_ack_seen) |=> src_req);

    // R4: request stays low until acknowledge seen low.
    p_req_waits_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (!src_req && src_ack_seen) |=> !src_req);

    // R4: acknowledge is up whenever a word is delivered.
    p_ack_with_valid_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |-> dst_ack);

    // R5: valid lasts one destination cycle.
    p_valid_pulse_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid);

    // R6: output word changes only together with valid.
    p_data_hold_r6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_valid |-> $stable(dst_data));

endmodule

bind bus_handshake_cdc bus_handshake_cdc_chk #(.DATA_W(DATA_W)) u_chk (
    .src_clk      (src_clk),
    .src_rst_n    (src_rst_n),
    .src_valid    (src_valid),
    .src_ready    (src_ready),
    .src_req      (req_src),
    .src_ack_seen (ack_src),
    .hold         (hold_bus),
    .dst_clk      (dst_clk),
    .dst_rst_n    (dst_rst_n),
    .dst_valid    (dst_valid),
    .dst_data     (dst_data),
    .dst_ack      (ack_dst)
);

// File: tb/bus_handshake_cdc_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural queue model of taken words, checked on
// every source and destination clock at the falling edge.
module bus_handshake_cdc_bench;

    localparam int  DATA_W     = 16;
    localparam int  STAGES     = 2;
    localparam int  SRC_PERIOD = 10;
    localparam real DST_PERIOD = 6.2;
    localparam int  MIN_BUSY   = 2 * STAGES;
    localparam int  MAX_BUSY   = 4 * STAGES + 12;

    logic              src_clk = 1'b0;
    logic              dst_clk = 1'b0;
    logic              src_rst_n = 1'b0;
    logic              dst_rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_ready;
    logic [DATA_W-1:0] dst_data;
    logic              dst_valid;

    int checks   = 0;
    int failures = 0;
    int taken    = 0;
    int delivered = 0;
    int low_run  = 0;
    bit acc_last = 1'b0;
    bit finished = 1'b0;
    bit prev_valid = 1'b0;
    logic [DATA_W-1:0] last_data = '0;
    logic [DATA_W-1:0] exp_q[$];

    always #(SRC_PERIOD / 2) src_clk = ~src_clk;
    always #(DST_PERIOD / 2.0) dst_clk = ~dst_clk;

    bus_handshake_cdc #(.DATA_W(DATA_W), .STAGES(STAGES)) u_bus_handshake_cdc (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_data  (dst_data),
        .dst_valid (dst_valid)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One source cycle: check ready history, then drive the next inputs.
    task automatic src_cycle(input logic v, input logic [DATA_W-1:0] d);
        @(negedge src_clk);
        if (acc_last) chk(src_ready == 1'b0, "R2 ready low after take", src_ready, 0);
        if (!src_ready) begin
            low_run++;
            if (low_run == MAX_BUSY + 1)
                chk(1'b0, "R8 ready not back in bound", low_run, MAX_BUSY);
        end else begin
            if (low_run > 0) begin
                chk(low_run >= MIN_BUSY, "R3 busy window too short", low_run, MIN_BUSY);
                chk(low_run <= MAX_BUSY, "R8 busy window too long", low_run, MAX_BUSY);
            end
            low_run = 0;
        end
        src_valid = v;
        src_data  = d;
        acc_last  = v && src_ready;
        if (acc_last) begin
            exp_q.push_back(d);
            taken++;
        end
    endtask

    // Let outstanding words drain.
    task automatic drain();
        for (int i = 0; i < 300; i++) begin
            if (exp_q.size() == 0 && src_ready && low_run == 0 && !acc_last) break;
            src_cycle(1'b0, 16'hDEAD);
        end
        src_cycle(1'b0, '0);
    endtask

    // Destination-side model comparison on every destination cycle.
    always @(negedge dst_clk) begin
        if (dst_rst_n && !finished) begin
            if (dst_valid) begin
                chk(!prev_valid, "R5 valid two cycles", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 pulse without taken word", dst_data, 0);
                end else begin
                    chk(dst_data == exp_q[0], "R6 R7 delivered word", dst_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                delivered++;
                last_data = dst_data;
            end else begin
                chk(dst_data == last_data, "R6 data moved without valid", dst_data, last_data);
            end
            prev_valid = dst_valid;
        end
    end

    initial begin
        #(SRC_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] lfsr;
        // Reset both domains.
        repeat (6) @(negedge src_clk);
        chk(src_ready == 1'b1, "R1 ready in reset", src_ready, 1);
        @(negedge dst_clk);
        chk(dst_valid == 1'b0, "R1 valid in reset", dst_valid, 0);
        chk(dst_data == '0, "R1 data in reset", dst_data, 0);
        dst_rst_n = 1'b1;
        @(negedge src_clk);
        src_rst_n = 1'b1;
        @(negedge src_clk);
        chk(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);

        // Single words, including all-zero and all-ones patterns (R6, R7).
        src_cycle(1'b1, 16'hA5C3);
        drain();
        src_cycle(1'b1, 16'h0000);
        drain();
        src_cycle(1'b1, 16'hFFFF);
        drain();

        // Valid held with data changing every cycle: words offered while
        // ready is low must be ignored (R3), others delivered in order (R7).
        for (int i = 0; i < 400; i++) src_cycle(1'b1, 16'(i * 16'h0107 + 16'h3000));
        drain();

        // Sparse offers with a pseudo-random pattern (R2, R7).
        lfsr = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            src_cycle(lfsr[0] & lfsr[3], lfsr);
        end
        drain();

        // End of run: everything taken was delivered once (R7).
        repeat (20) @(negedge dst_clk);
        chk(exp_q.size() == 0, "R7 words left undelivered", exp_q.size(), 0);
        chk(delivered == taken, "R7 delivered count", delivered, taken);
        chk(taken > 50, "R2 words taken", taken, 50);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule